// File: doc/BRIEF.md
# Range Coder Interval Division Unit

This unit carries out the per-symbol interval split of an adaptive binary range encoder. It keeps three 32-bit registers: the interval base (low), the interval width (range) and an auxiliary top (high = low + range). For each accepted symbol it derives the sub-range width T from the current range and from the probability state of the active window. The probability state is given as a window exponent w and a state value s. The unit then moves the interval to the part that belongs to the coded symbol.

T comes from one of two routes. When the estimated probability lies below 2^-8, T is approximated by shifts and adds of range. Otherwise it is a narrowed 24x8 product. All candidate widths are formed in parallel, and a selector picks one per symbol. The selector is an enumerated code named SEL_D0, SEL_D1, SEL_D2, SEL_D3, SEL_D47 or SEL_MUL.

The unit has no sequencing states. Each clock with the strobe high takes the UPDATE transition and loads all three registers. Each clock with the strobe low takes the HOLD transition. Reset enters the INIT condition. Probability adaptation and byte output belong to neighbouring blocks. The caller keeps range at or above 2^8 whenever a symbol is presented.

Top module: `range_div_unit`

## Requirements
- R1: Reset sets low to 0, range to 0xFFFFFFFF and high to 0xFFFFFFFF.
- R2: With in_valid low at a clock edge, low, range and high keep their values whatever the other inputs carry.
- R3: When sym_bit equals mps_bit, the next values are high' = low + range, low' = high' - T and range' = T. All sums are taken modulo 2^32 and use the old register values.
- R4: When sym_bit differs from mps_bit, the next values are range' = range - T, low' = low and high' = low + range'.
- R5: The multiply route applies when w is 6 or less, or when s is at least 2^(2w-8). On this route T = (range >> 8) * T2. T2 is the 8-bit value s >> (2w-8), or s << (8-2w) when 2w < 8.
- R6: The shift route applies when w is 7 or more and s is below 2^(2w-8). On this route the index d = bits [2w-9 : 2w-11] of s selects T. For d=0, T = range>>13. For d=1, T = range>>11. For d=2, T = range>>10. For d=3, T = (range>>10)+(range>>11). For d=4 to 7, T = (range>>9)+(range>>10).
- R7: On the shift route a computed T of zero is replaced by 1.
- R8: One symbol is accepted per clock. Its result appears on the outputs after the next rising edge, and back-to-back symbols chain through the registered values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol strobe; high loads the registers |
| sym_bit | input | 1 | Binary symbol to code |
| mps_bit | input | 1 | Current most probable symbol value |
| win_exp | input | 4 | Window exponent w (1 to 10) |
| win_state | input | 20 | Window state s |
| low_o | output | 32 | Interval base register |
| range_o | output | 32 | Interval width register |
| high_o | output | 32 | Auxiliary top register (low + range) |

## Verification
The bench builds the unit with its default widths: 32-bit registers, a maximum window exponent of 10 and an 8-bit T2. This makes every window exponent from 1 to 10 reachable. For each exponent the bench sweeps s across every subinterval boundary, both inside and at the edge of each shift-route index, up to the multiply threshold and the top state. Every such s value is driven with both symbol and MPS combinations, so the two update directions meet every T route. A directed chain drives range below 8192 before a shift-route symbol, which brings the floor-to-one case within reach. Idle cycles with changing inputs cover the hold behaviour.

// File: rtl/rcdiv_pkg.sv
package rcdiv_pkg;
    // Selection among the six parallel sub-range candidates
    typedef enum logic [2:0] {
        SEL_D0  = 3'd0,
        SEL_D1  = 3'd1,
        SEL_D2  = 3'd2,
        SEL_D3  = 3'd3,
        SEL_D47 = 3'd4,
        SEL_MUL = 3'd5
    } sel_e;

    // Lowest window exponent that can reach the shift route
    localparam int FINE_EXP  = 7;
    // Offset of the 3-bit subinterval index below the multiply threshold
    localparam int IDX_BITS  = 3;
    // Shift amounts of the low-probability approximations
    localparam int SH_D0     = 13;
    localparam int SH_D1     = 11;
    localparam int SH_D2     = 10;
    localparam int SH_HI     = 9;
endpackage

// File: rtl/rcdiv_index.sv
module rcdiv_index
    import rcdiv_pkg::*;
#(
    parameter int EXP_W   = 4,
    parameter int STATE_W = 20,
    parameter int T2_W    = 8
) (
    input  logic [EXP_W-1:0]   win_exp,
    input  logic [STATE_W-1:0] win_state,
    output logic [T2_W-1:0]    t2,
    output sel_e               sel
);
    localparam int SHW     = STATE_W + T2_W;
    localparam int DW      = EXP_W + 1;
    localparam int IDX_OFF = T2_W + IDX_BITS;

    logic [DW-1:0]      dbl;
    logic [SHW-1:0]     scaled;
    logic [STATE_W-1:0] idx_sh;
    logic [IDX_BITS-1:0] dval;
    logic               fine_zone;

    assign dbl = {win_exp, 1'b0};

    always_comb begin
        if (dbl >= DW'(T2_W))
            scaled = SHW'(win_state) >> (dbl - DW'(T2_W));
        else
            scaled = SHW'(win_state) << (DW'(T2_W) - dbl);
    end

    assign idx_sh    = win_state >> (dbl - DW'(IDX_OFF));
    assign dval      = idx_sh[IDX_BITS-1:0];
    assign fine_zone = (win_exp >= EXP_W'(FINE_EXP)) && (scaled == '0);
    assign t2        = scaled[T2_W-1:0];

    always_comb begin
        if (!fine_zone) begin
            sel = SEL_MUL;
        end else begin
            unique case (dval)
                3'd0:    sel = SEL_D0;
                3'd1:    sel = SEL_D1;
                3'd2:    sel = SEL_D2;
                3'd3:    sel = SEL_D3;
                default: sel = SEL_D47;
            endcase
        end
    end
endmodule

// File: rtl/rcdiv_tcalc.sv
module rcdiv_tcalc
    import rcdiv_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int T2_W  = 8
) (
    input  logic [REG_W-1:0] range_q,
    input  logic [T2_W-1:0]  t2,
    input  sel_e             sel,
    output logic [REG_W-1:0] sub_t
);
    localparam int T1_W = REG_W - 8;

    logic [T1_W-1:0]  t1;
    logic [REG_W-1:0] c_d0, c_d1, c_d2, c_d3, c_d47, c_mul;
    logic [REG_W-1:0] raw;

    assign t1    = range_q[REG_W-1:8];
    assign c_d0  = range_q >> SH_D0;
    assign c_d1  = range_q >> SH_D1;
    assign c_d2  = range_q >> SH_D2;
    assign c_d3  = (range_q >> SH_D2) + (range_q >> SH_D1);
    assign c_d47 = (range_q >> SH_HI) + (range_q >> SH_D2);
    assign c_mul = REG_W'(t1) * REG_W'(t2);

    always_comb begin
        unique case (sel)
            SEL_D0:  raw = c_d0;
            SEL_D1:  raw = c_d1;
            SEL_D2:  raw = c_d2;
            SEL_D3:  raw = c_d3;
            SEL_D47: raw = c_d47;
            default: raw = c_mul;
        endcase
    end

    // Shift route floors at one; multiply route is positive for range >= 2^8
    assign sub_t = (sel != SEL_MUL && raw == '0) ? REG_W'(1) : raw;
endmodule

// File: rtl/rcdiv_update.sv
module rcdiv_update #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             sym_bit,
    input  logic             mps_bit,
    input  logic [REG_W-1:0] sub_t,
    output logic [REG_W-1:0] low_q,
    output logic [REG_W-1:0] range_q,
    output logic [REG_W-1:0] high_q
);
    logic [REG_W-1:0] low_d, range_d, high_d;

    always_comb begin
        if (sym_bit == mps_bit) begin
            high_d  = low_q + range_q;
            low_d   = high_d - sub_t;
            range_d = sub_t;
        end else begin
            range_d = range_q - sub_t;
            low_d   = low_q;
            high_d  = low_q + range_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= '0;
            range_q <= '1;
            high_q  <= '1;
        end else if (in_valid) begin
            low_q   <= low_d;
            range_q <= range_d;
            high_q  <= high_d;
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(low_q) && $stable(range_q) && $stable(high_q));

    // R3
    mps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sym_bit == mps_bit) |=> high_q == $past(low_q + range_q));

    // R4
    lps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sym_bit != mps_bit) |=> $stable(low_q));

    // R4
    top_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_q == low_q + range_q);

    // R7
    range_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && range_q >= REG_W'(256)) |=> (range_q != '0) && (range_q < $past(range_q)));
endmodule

// File: rtl/range_div_unit.sv
module range_div_unit
    import rcdiv_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int MAX_EXP = 10,
    parameter int EXP_W   = 4,
    parameter int T2_W    = 8,
    localparam int STATE_W = 2 * MAX_EXP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               sym_bit,
    input  logic               mps_bit,
    input  logic [EXP_W-1:0]   win_exp,
    input  logic [STATE_W-1:0] win_state,
    output logic [REG_W-1:0]   low_o,
    output logic [REG_W-1:0]   range_o,
    output logic [REG_W-1:0]   high_o
);
    logic [T2_W-1:0]  t2;
    sel_e             sel;
    logic [REG_W-1:0] sub_t;

    rcdiv_index #(.EXP_W(EXP_W), .STATE_W(STATE_W), .T2_W(T2_W)) u_index (
        .win_exp   (win_exp),
        .win_state (win_state),
        .t2        (t2),
        .sel       (sel)
    );

    rcdiv_tcalc #(.REG_W(REG_W), .T2_W(T2_W)) u_tcalc (
        .range_q (range_o),
        .t2      (t2),
        .sel     (sel),
        .sub_t   (sub_t)
    );

    rcdiv_update #(.REG_W(REG_W)) u_update (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .sym_bit  (sym_bit),
        .mps_bit  (mps_bit),
        .sub_t    (sub_t),
        .low_q    (low_o),
        .range_q  (range_o),
        .high_q   (high_o)
    );
endmodule

// File: tb/range_div_unit_tb.sv
module range_div_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sym_bit = 1'b0;
    logic        mps_bit = 1'b0;
    logic [3:0]  win_exp = 4'd5;
    logic [19:0] win_state = 20'd16;
    logic [31:0] low_o, range_o, high_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_low, m_range, m_high;

    always #2 clk = ~clk;

    range_div_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_bit(sym_bit),
        .mps_bit(mps_bit), .win_exp(win_exp), .win_state(win_state),
        .low_o(low_o), .range_o(range_o), .high_o(high_o)
    );

    function automatic logic [31:0] exp_t(logic [31:0] r, int w, logic [19:0] s, output bit fine);
        logic [63:0] wide;
        logic [31:0] t;
        int d;
        if (2*w >= 8) wide = 64'(s) >> (2*w - 8);
        else          wide = 64'(s) << (8 - 2*w);
        fine = (w >= 7) && (wide == 64'd0);
        if (fine) begin
            d = int'((s >> (2*w - 11)) & 20'd7);
            case (d)
                0: t = r >> 13;
                1: t = r >> 11;
                2: t = r >> 10;
                3: t = (r >> 10) + (r >> 11);
                default: t = (r >> 9) + (r >> 10);
            endcase
            if (t == 32'd0) t = 32'd1;
        end else begin
            t = 32'(64'(r >> 8) * 64'(wide[7:0]));
        end
        return t;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_low = 32'd0; m_range = 32'hFFFF_FFFF; m_high = 32'hFFFF_FFFF;
        check(low_o == m_low, "R1 low", low_o, m_low);
        check(range_o == m_range && high_o == m_high, "R1 range/high", range_o, m_range);
    endtask

    // Caller is at a negedge; drives one symbol and checks at the next negedge
    task automatic step(bit sb, bit mb, int w, logic [19:0] s);
        logic [31:0] t;
        bit fine;
        string dir;
        if (m_range < 32'd256) do_reset();
        t = exp_t(m_range, w, s, fine);
        if (sb == mb) begin
            m_high = m_low + m_range; m_low = m_high - t; m_range = t; dir = "R3";
        end else begin
            m_range = m_range - t; m_high = m_low + m_range; dir = "R4";
        end
        sym_bit = sb; mps_bit = mb; win_exp = 4'(w); win_state = s; in_valid = 1'b1;
        @(negedge clk);
        check(low_o == m_low && high_o == m_high, {dir, " low/high R8"}, low_o, m_low);
        if (fine)
            check(range_o == m_range, (t == 32'd1) ? "R7 R6 range" : "R6 range", range_o, m_range);
        else
            check(range_o == m_range, "R5 range", range_o, m_range);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R5 R6: sweep every exponent, subinterval boundaries, both directions
        for (int w = 1; w <= 10; w++) begin
            for (int k = 0; k < 20; k++) begin
                logic [19:0] s;
                bit use_it;
                use_it = 1'b1;
                s = 20'd1;
                if (w <= 6) begin
                    case (k)
                        0: s = (2*w >= 8) ? 20'(1 << (2*w - 8)) : 20'd1;
                        1: s = 20'(1 << (2*w - 2));
                        2: s = 20'(1 << (2*w - 1));
                        default: use_it = 1'b0;
                    endcase
                end else begin
                    if (k <= 8)       s = 20'(k << (2*w - 11));
                    else if (k <= 16) s = 20'(((k - 9) << (2*w - 11)) | ((1 << (2*w - 11)) - 1));
                    else if (k == 17) s = 20'(1 << (2*w - 1));
                    else use_it = 1'b0;
                end
                if (use_it) begin
                    for (int c = 0; c < 4; c++) begin
                        step(c[0], c[1], w, s);
                        step(1'b0, 1'b1, w, s);
                    end
                end
            end
        end

        // R7: drive range below 8192, then a shift-route symbol with zero raw T
        do_reset();
        step(1'b1, 1'b1, 5, 20'd4);
        step(1'b1, 1'b1, 5, 20'd4);
        step(1'b0, 1'b0, 5, 20'd8);
        step(1'b1, 1'b0, 7, 20'd0);
        step(1'b1, 1'b0, 10, 20'd100);

        // R2: idle cycles with changing inputs leave the registers unchanged
        do_reset();
        step(1'b0, 1'b1, 8, 20'd70000);
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sym_bit = i[0]; mps_bit = ~i[0]; win_exp = 4'(3 + i); win_state = 20'(i * 5 + 1);
            @(negedge clk);
            check(low_o == m_low && range_o == m_range && high_o == m_high,
                  "R2 hold", range_o, m_range);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule